// File: doc/BRIEF.md
# Ping-Pong Radix-2 FFT Stage Sequencer

This block sequences a 256-point decimation-in-time FFT that works out of two pairs of dual-port buffers. One pair holds real samples and the other holds imaginary samples. Both pairs are driven by the same select and address lines, so they are always handled identically and at the same time. The block assumes the input loader has already placed the samples in bit-reversed order.

After a start pulse the block runs the eight radix-2 stages. In each stage it issues 128 butterflies. For every butterfly it drives both operand addresses onto the two ports of the current read buffer, together with a twiddle-table index. It then replays the same addresses as a write to the opposite buffer once the external butterfly pipeline has had time to produce a result. The read and write roles swap after every stage. The first stage reads buffer A and writes buffer B, so the eighth stage leaves the result in buffer A.

A final pass reads buffer A at addresses 0 to 255, one per cycle. Each real/imaginary pair is packed into one 32-bit word and streamed out. A one-cycle `done` pulse accompanies the last word. The butterfly arithmetic and the loader are outside this block.

Top module: `fft_pingpong_seq`

## Requirements
- R1: While reset is held and just after it, `done`, `rdEn`, `wrEn` and `outValid` are 0.
- R2: A start pulse seen in idle begins a run in the next cycle. The run has exactly 8 stages of exactly 128 butterfly reads each, numbered b = 0..127 in ascending order.
- R3: In stage s (0..7), butterfly b = g·2^s + j (0 ≤ j < 2^s) reads top address g·2^(s+1) + j on `rdAddrTop` and top + 2^s on `rdAddrBot`. Its twiddle index on `twAddr` is j·2^(7−s).
- R4: `rdSelB` selects the read buffer (0 = A, 1 = B). It is 0 in even stages (including the first stage, s = 0) and 1 in odd stages.
- R5: Every butterfly read reappears as a write (`wrEn`) exactly BFLY_LAT cycles later, with the same two addresses. `wrSelB` during that write is the inverse of the read select.
- R6: The first read of a stage comes BFLY_LAT+1 cycles after the last read of the previous stage, so stage s, butterfly b is read in cycle s·(128+BFLY_LAT)+b after the run begins.
- R7: The output pass starts BFLY_LAT+1 cycles after the last read of stage 7. It reads buffer A (`rdSelB` = 0) at addresses 0..255 in order, one per cycle, and no write occurs during it.
- R8: One cycle after each output read, `outValid` is 1 and `outWord` = {imaginary[15:0], real[15:0]} of the data returned for that address. The real part is in bits 15:0 and the imaginary part in bits 31:16.
- R9: `done` is high for exactly one cycle per run. It coincides with the last output word, 8·(128+BFLY_LAT)+256 cycles after the run begins.
- R10: A start pulse while a run is in progress has no effect on addresses, timing or the number of `done` pulses.
- R11: Whenever a read and a write are active in the same cycle, they target different buffers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a transform when idle |
| done | output | 1 | One-cycle pulse with the last output word |
| rdEn | output | 1 | Read strobe to the selected buffer of both pairs |
| rdSelB | output | 1 | Read buffer select, 0 = A, 1 = B |
| rdAddrTop | output | 8 | Port-1 read address (upper butterfly leg or output index) |
| rdAddrBot | output | 8 | Port-2 read address (lower butterfly leg) |
| twAddr | output | 7 | Twiddle table index |
| wrEn | output | 1 | Write strobe for butterfly results |
| wrSelB | output | 1 | Write buffer select, 0 = A, 1 = B |
| wrAddrTop | output | 8 | Port-1 write address |
| wrAddrBot | output | 8 | Port-2 write address |
| reData | input | 16 | Real data returned by port 1 of the read buffer |
| imData | input | 16 | Imaginary data returned by port 1 of the read buffer |
| outValid | output | 1 | Output word valid |
| outWord | output | 32 | Packed result, imaginary high, real low |

## Verification
Within a stage, the write of butterfly b−BFLY_LAT and the read of butterfly b happen in the same cycle on opposite buffers. The bench runs whole transforms so that this overlap happens on every cycle of every stage. A scoreboard checks the read stream and the write stream each against its own queue of expected cycle, addresses and select, and flags any cycle where both are active with equal selects. A second coincidence is the last output word arriving in the same cycle as `done`; its cycle number is predicted from the stage count and latency and compared on both signals. A spurious start is injected mid-run to show that nothing shifts.

// File: rtl/fft_seq_pkg.sv
package fft_seq_pkg;
  parameter int PTS_LOG2 = 8;
  localparam int STG_W = $clog2(PTS_LOG2);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_DRAIN,
    ST_OUT,
    ST_FIN
  } seqState_t;

  typedef struct packed {
    logic                issue;
    logic                outRd;
    logic [STG_W-1:0]    stage;
    logic [PTS_LOG2-1:0] idx;
  } seqCtrl_t;
endpackage

// File: rtl/fft_seq_ctrl.sv
module fft_seq_ctrl
  import fft_seq_pkg::*;
#(
  parameter int BFLY_LAT = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  output seqCtrl_t ctl,
  output logic     done
);
  localparam int NPTS = 1 << PTS_LOG2;
  localparam int HALF = NPTS / 2;
  localparam int DR_W = (BFLY_LAT > 1) ? $clog2(BFLY_LAT) : 1;
  localparam logic [PTS_LOG2-1:0] LAST_BFLY = PTS_LOG2'(HALF - 1);
  localparam logic [PTS_LOG2-1:0] LAST_OUT  = PTS_LOG2'(NPTS - 1);
  localparam logic [STG_W-1:0]    LAST_STG  = STG_W'(PTS_LOG2 - 1);
  localparam logic [DR_W-1:0]     LAST_DR   = DR_W'(BFLY_LAT - 1);

  seqState_t           state;
  logic [STG_W-1:0]    stage;
  logic [PTS_LOG2-1:0] idx;
  logic [DR_W-1:0]     drainCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      stage    <= '0;
      idx      <= '0;
      drainCnt <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_RUN;
            stage <= '0;
            idx   <= '0;
          end
        end
        ST_RUN: begin
          if (idx == LAST_BFLY) begin
            idx      <= '0;
            drainCnt <= '0;
            state    <= ST_DRAIN;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_DRAIN: begin
          if (drainCnt == LAST_DR) begin
            if (stage == LAST_STG) begin
              state <= ST_OUT;
            end else begin
              stage <= stage + 1'b1;
              state <= ST_RUN;
            end
          end else begin
            drainCnt <= drainCnt + 1'b1;
          end
        end
        ST_OUT: begin
          if (idx == LAST_OUT) begin
            idx   <= '0;
            done  <= 1'b1;
            state <= ST_FIN;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.issue = (state == ST_RUN);
    ctl.outRd = (state == ST_OUT);
    ctl.stage = stage;
    ctl.idx   = idx;
  end

  // R9: done never lasts two cycles
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2: butterfly counter never leaves the lower half during a stage
  a_r2_idx_in_half: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |-> !idx[PTS_LOG2-1]);

  // R10: a busy run is not cut short by any input
  a_r10_stay_busy: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN || state == ST_DRAIN || state == ST_OUT) |=> (state != ST_IDLE));
endmodule

// File: rtl/fft_seq_dp.sv
module fft_seq_dp
  import fft_seq_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int BFLY_LAT = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  seqCtrl_t              ctl,
  input  logic [DATA_W-1:0]     reData,
  input  logic [DATA_W-1:0]     imData,
  output logic                  rdEn,
  output logic                  rdSelB,
  output logic [PTS_LOG2-1:0]   rdAddrTop,
  output logic [PTS_LOG2-1:0]   rdAddrBot,
  output logic [PTS_LOG2-2:0]   twAddr,
  output logic                  wrEn,
  output logic                  wrSelB,
  output logic [PTS_LOG2-1:0]   wrAddrTop,
  output logic [PTS_LOG2-1:0]   wrAddrBot,
  output logic                  outValid,
  output logic [2*DATA_W-1:0]   outWord
);
  localparam int AW = PTS_LOG2;
  localparam int BW = PTS_LOG2 - 1;

  logic [BW-1:0]    bfly, lowMask, jPart, grpPart;
  logic [AW-1:0]    topAddr, botAddr, spanBit;
  logic [STG_W-1:0] twShift;

  always_comb begin
    bfly    = ctl.idx[BW-1:0];
    lowMask = ~({BW{1'b1}} << ctl.stage);
    jPart   = bfly & lowMask;
    grpPart = bfly & ~lowMask;
    spanBit = AW'(1) << ctl.stage;
    topAddr = {grpPart, 1'b0} | {1'b0, jPart};
    botAddr = topAddr | spanBit;
    twShift = STG_W'(BW) - ctl.stage;
  end

  always_comb begin
    rdEn      = ctl.issue | ctl.outRd;
    rdSelB    = ctl.issue & ctl.stage[0];
    rdAddrTop = ctl.outRd ? ctl.idx : (ctl.issue ? topAddr : '0);
    rdAddrBot = ctl.issue ? botAddr : '0;
    twAddr    = ctl.issue ? (jPart << twShift) : '0;
  end

  // Write replay pipeline: matches the external butterfly latency
  logic          pV   [BFLY_LAT];
  logic          pSel [BFLY_LAT];
  logic [AW-1:0] pTop [BFLY_LAT];
  logic [AW-1:0] pBot [BFLY_LAT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < BFLY_LAT; k++) begin
        pV[k]   <= 1'b0;
        pSel[k] <= 1'b0;
        pTop[k] <= '0;
        pBot[k] <= '0;
      end
    end else begin
      pV[0]   <= ctl.issue;
      pSel[0] <= ~ctl.stage[0];
      pTop[0] <= topAddr;
      pBot[0] <= botAddr;
      for (int k = 1; k < BFLY_LAT; k++) begin
        pV[k]   <= pV[k-1];
        pSel[k] <= pSel[k-1];
        pTop[k] <= pTop[k-1];
        pBot[k] <= pBot[k-1];
      end
    end
  end

  assign wrEn      = pV[BFLY_LAT-1];
  assign wrSelB    = pSel[BFLY_LAT-1];
  assign wrAddrTop = pTop[BFLY_LAT-1];
  assign wrAddrBot = pBot[BFLY_LAT-1];

  // Output packer: buffer read latency is one cycle
  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= ctl.outRd;
  end

  assign outWord = outValid ? {imData, reData} : '0;

  // R11: concurrent read and write never share a buffer
  a_r11_sel_apart: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && wrEn) |-> (rdSelB != wrSelB));

  // R7: the write pipeline has drained before the output pass
  a_r7_quiet_output: assert property (@(posedge clk) disable iff (!rstN)
    ctl.outRd |-> !wrEn);
endmodule

// File: rtl/fft_pingpong_seq.sv
module fft_pingpong_seq
  import fft_seq_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int BFLY_LAT = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  output logic                  done,
  output logic                  rdEn,
  output logic                  rdSelB,
  output logic [PTS_LOG2-1:0]   rdAddrTop,
  output logic [PTS_LOG2-1:0]   rdAddrBot,
  output logic [PTS_LOG2-2:0]   twAddr,
  output logic                  wrEn,
  output logic                  wrSelB,
  output logic [PTS_LOG2-1:0]   wrAddrTop,
  output logic [PTS_LOG2-1:0]   wrAddrBot,
  input  logic [DATA_W-1:0]     reData,
  input  logic [DATA_W-1:0]     imData,
  output logic                  outValid,
  output logic [2*DATA_W-1:0]   outWord
);
  seqCtrl_t ctl;

  fft_seq_ctrl #(.BFLY_LAT(BFLY_LAT)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .ctl(ctl), .done(done)
  );

  fft_seq_dp #(.DATA_W(DATA_W), .BFLY_LAT(BFLY_LAT)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reData(reData), .imData(imData),
    .rdEn(rdEn), .rdSelB(rdSelB), .rdAddrTop(rdAddrTop), .rdAddrBot(rdAddrBot),
    .twAddr(twAddr), .wrEn(wrEn), .wrSelB(wrSelB), .wrAddrTop(wrAddrTop),
    .wrAddrBot(wrAddrBot), .outValid(outValid), .outWord(outWord)
  );
endmodule

// File: tb/fft_pingpong_seq_test.sv
`timescale 1ns/1ps
module fft_pingpong_seq_test;
  localparam int LAT  = 4;
  localparam int NPTS = 256;
  localparam int HALF = 128;
  localparam int NSTG = 8;
  localparam int STRIDE = HALF + LAT;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, start, done, rdEn, rdSelB, wrEn, wrSelB, outValid;
  logic [7:0] rdAddrTop, rdAddrBot, wrAddrTop, wrAddrBot;
  logic [6:0] twAddr;
  logic [15:0] reData, imData;
  logic [31:0] outWord;

  fft_pingpong_seq #(.DATA_W(16), .BFLY_LAT(LAT)) uut (
    .clk(clk), .rstN(rstN), .start(start), .done(done), .rdEn(rdEn),
    .rdSelB(rdSelB), .rdAddrTop(rdAddrTop), .rdAddrBot(rdAddrBot),
    .twAddr(twAddr), .wrEn(wrEn), .wrSelB(wrSelB), .wrAddrTop(wrAddrTop),
    .wrAddrBot(wrAddrBot), .reData(reData), .imData(imData),
    .outValid(outValid), .outWord(outWord)
  );

  typedef struct {
    int     n;
    longint a;
    longint b;
    longint t;
    int     sel;
  } ev_t;

  ev_t rdQ[$];
  ev_t wrQ[$];
  ev_t outQ[$];

  int cyc = 0;
  int base = 0;
  int seed = 0;
  int doneN = 0;
  int doneCnt = 0;
  bit running = 1'b0;
  int checks = 0;
  int errors = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] reFn(int a, int sd);
    return 16'(a * 37 + sd);
  endfunction
  function automatic logic [15:0] imFn(int a, int sd);
    return 16'(~(a * 5) ^ sd);
  endfunction

  // Buffer model: one-cycle read latency on port 1
  always @(posedge clk) begin
    reData <= reFn(int'(rdAddrTop), seed);
    imData <= imFn(int'(rdAddrTop), seed);
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc - base);
    end
  endtask

  // Monitor: pops expectations as the design produces them
  always @(negedge clk) begin
    if (running) begin
      int n;
      ev_t e;
      n = cyc - base;
      if (rdEn && wrEn) chk(rdSelB != wrSelB, "R11", "selects equal", rdSelB, !wrSelB);
      if (rdEn) begin
        if (rdQ.size() == 0) chk(1'b0, "R2", "unexpected read", rdAddrTop, 0);
        else begin
          e = rdQ.pop_front();
          chk(n == e.n, "R6", "read cycle", n, e.n);
          chk(rdAddrTop == e.a[7:0], "R3", "top address", rdAddrTop, e.a);
          chk(rdAddrBot == e.b[7:0], "R3", "bottom address", rdAddrBot, e.b);
          chk(twAddr == e.t[6:0], "R3", "twiddle", twAddr, e.t);
          chk(rdSelB == e.sel[0], "R4", "read select", rdSelB, e.sel);
        end
      end
      if (wrEn) begin
        if (wrQ.size() == 0) chk(1'b0, "R5", "unexpected write", wrAddrTop, 0);
        else begin
          e = wrQ.pop_front();
          chk(n == e.n, "R5", "write cycle", n, e.n);
          chk(wrAddrTop == e.a[7:0], "R5", "write top", wrAddrTop, e.a);
          chk(wrAddrBot == e.b[7:0], "R5", "write bottom", wrAddrBot, e.b);
          chk(wrSelB == e.sel[0], "R5", "write select", wrSelB, e.sel);
        end
      end
      if (outValid) begin
        if (outQ.size() == 0) chk(1'b0, "R8", "unexpected word", outWord, 0);
        else begin
          e = outQ.pop_front();
          chk(n == e.n, "R8", "word cycle", n, e.n);
          chk(outWord == e.a[31:0], "R8", "packed word", outWord, e.a);
        end
      end
      if (done) begin
        doneCnt++;
        chk(n == doneN, "R9", "done cycle", n, doneN);
        chk(outValid, "R9", "done without last word", outValid, 1);
      end
    end
  end

  // Driver: pushes expectations, then starts the transform
  task automatic runTransform(input int sd, input bit poke);
    seed = sd;
    for (int s = 0; s < NSTG; s++) begin
      for (int b = 0; b < HALF; b++) begin
        int g, j, top, bot, tw, n;
        g = b >> s;
        j = b % (1 << s);
        top = g * (2 << s) + j;
        bot = top + (1 << s);
        tw = j * (1 << (7 - s));
        n = s * STRIDE + b;
        rdQ.push_back('{n, top, bot, tw, s % 2});
        wrQ.push_back('{n + LAT, top, bot, 0, 1 - (s % 2)});
      end
    end
    for (int i = 0; i < NPTS; i++) begin
      longint w;
      w = {32'd0, imFn(i, sd), reFn(i, sd)};
      rdQ.push_back('{NSTG * STRIDE + i, i, 0, 0, 0});   // R7: buffer A, ascending
      outQ.push_back('{NSTG * STRIDE + i + 1, w, 0, 0, 0});
    end
    doneN = NSTG * STRIDE + NPTS;
    doneCnt = 0;
    @(negedge clk);
    base = cyc + 1;
    running = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R10: stray start in the middle of stage 2
      repeat (300) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (doneCnt == 0 && (cyc - base) < 3 * doneN) @(negedge clk);
    if (doneCnt == 0) chk(1'b0, "R9", "watchdog: no done", 0, 1);
    repeat (LAT + 4) @(negedge clk);
    running = 1'b0;
    chk(doneCnt == 1, "R10", "done pulses per run", doneCnt, 1);
    chk(rdQ.size() == 0, "R2", "reads left over", rdQ.size(), 0);
    chk(wrQ.size() == 0, "R5", "writes left over", wrQ.size(), 0);
    chk(outQ.size() == 0, "R8", "words left over", outQ.size(), 0);
    chk(!rdEn && !wrEn && !outValid, "R1", "idle after run", {rdEn, wrEn, outValid}, 0);
    rdQ.delete(); wrQ.delete(); outQ.delete();
  endtask

  initial begin
    rstN = 1'b0;
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk(!done && !rdEn && !wrEn && !outValid, "R1", "outputs in reset",
        {done, rdEn, wrEn, outValid}, 0);
    start = 1'b1;   // R1: start during reset is not taken
    @(negedge clk);
    start = 1'b0;
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(!done && !rdEn && !wrEn && !outValid, "R1", "outputs after reset",
        {done, rdEn, wrEn, outValid}, 0);
    runTransform(16'h1234, 1'b0);
    runTransform(16'h0BE5, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule